// File: doc/BRIEF.md
# Nested-Loop Transfer Engine

This block runs one transfer descriptor for a single channel. When the block is idle, a load pulse captures the starting source and destination addresses and the major iteration count. Each start pulse then runs one minor loop. A minor loop is a series of sized reads and writes on a request/acknowledge memory port. The engine moves a buffered element of the larger of the two access sizes, so that a narrow side makes several accesses for each access on the wide side. After each access the address on that side is advanced by a signed step. The step can be confined to a power-of-two circular window.

At the end of a minor loop the iteration count decrements. An optional signed loop offset is added to either address. When the count runs out, signed last-adjustments are applied to both addresses, the count reloads, and the done flag is set. The engine also emits interrupt pulses, a pulse to start a linked channel, and a request-clear pulse. An optional stall after every access limits how much bus bandwidth the engine takes. A bus error terminates the transfer.

Top module: `xfer_loop_engine`

## Requirements
- R1: `load_i` while idle captures both addresses and the count and clears `done_o`. `start_i` while idle raises `busy_o` and begins one minor loop. `mem_req_o` is only asserted while busy.
- R2: Size codes 0..5 select 1, 2, 4, 8, 16 or 32 bytes per access. Each element holds the larger of the two sizes. The narrower side performs (larger/smaller) accesses per element. Bytes are packed low-address-first on the low data lanes.
- R3: After each acknowledged read, the sign-extended 16-bit source step is added to the source address. After each acknowledged write, the destination step is added to the destination address.
- R4: A modulo code k in 1..31 keeps the address bits above bit k-1 unchanged and lets only the low k bits take the stepped sum. Code 0 disables wrapping.
- R5: A minor loop ends once the bytes moved reach `minor_bytes_i`. The iteration count then decrements by one.
- R6: When the count runs out, `src_last_i` and `dst_last_i` are added to the addresses and the count reloads from the loaded value. `done_o` is set. The count does not change while the engine is idle unless a load occurs.
- R7: After a minor loop that is not the final one, the sign-extended loop offset is added to the source address if `loop_off_src_en_i` is set, and to the destination address if `loop_off_dst_en_i` is set.
- R8: Bandwidth code 2 inserts 4 idle cycles after every access and code 3 inserts 8. Any other code inserts none. Each minor loop also spends exactly one bookkeeping cycle.
- R9: `int_half_o` pulses, if `half_ie_i` is set, when the count decrements to half of the loaded count (integer halving). The loaded count must be at least 2 for this pulse.
- R10: `int_major_o` pulses, if `major_ie_i` is set, when the count runs out.
- R11: Link mode 1 pulses `link_go_o` at every decrement and mode 2 pulses it only when the count runs out. `link_ch_o` carries the target channel.
- R12: With `auto_stop_i` set, `hw_req_clr_o` pulses once, at major completion only.
- R13: A minor-mode link to this channel's own number with `cont_link_i` set restarts the next minor loop at once, with no link pulse. The final loop ends idle and pulses the link.
- R14: An error response on a read pulses `err_src_o`, and one on a write pulses `err_dst_o`. Either error ends the transfer idle without setting done, and the failing write stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| load_i | input | 1 | capture descriptor addresses and count |
| start_i | input | 1 | service request: run one minor loop |
| src_addr_i | input | AW | starting source address |
| dst_addr_i | input | AW | starting destination address |
| src_size_i | input | 3 | source access size code |
| dst_size_i | input | 3 | destination access size code |
| src_step_i | input | 16 | signed source step per read |
| dst_step_i | input | 16 | signed destination step per write |
| src_mod_i | input | 5 | source modulo code |
| dst_mod_i | input | 5 | destination modulo code |
| minor_bytes_i | input | NBW | bytes per minor loop |
| major_iter_i | input | CW | major iteration count |
| src_last_i | input | AW | signed source adjustment at completion |
| dst_last_i | input | AW | signed destination adjustment at completion |
| loop_off_i | input | MLW | signed minor loop offset |
| loop_off_src_en_i | input | 1 | apply loop offset to source |
| loop_off_dst_en_i | input | 1 | apply loop offset to destination |
| bw_code_i | input | 2 | stall code |
| half_ie_i | input | 1 | half interrupt enable |
| major_ie_i | input | 1 | major interrupt enable |
| link_mode_i | input | 2 | 0 none, 1 per minor loop, 2 at completion |
| link_ch_i | input | CHW | linked channel number |
| cont_link_i | input | 1 | continuous self-link enable |
| auto_stop_i | input | 1 | clear hardware request at completion |
| mem_req_o | output | 1 | access request |
| mem_we_o | output | 1 | 1 for write |
| mem_addr_o | output | AW | access address |
| mem_size_o | output | 3 | access size code |
| mem_wdata_o | output | 8*MAXB | write data, low lanes |
| mem_ack_i | input | 1 | access acknowledge |
| mem_err_i | input | 1 | error response, valid with ack |
| mem_rdata_i | input | 8*MAXB | read data, low lanes |
| busy_o | output | 1 | minor loop in progress |
| done_o | output | 1 | major loop complete |
| src_addr_o | output | AW | current source address |
| dst_addr_o | output | AW | current destination address |
| citer_o | output | CW | current iteration count |
| int_half_o | output | 1 | half interrupt pulse |
| int_major_o | output | 1 | major interrupt pulse |
| link_go_o | output | 1 | linked channel start pulse |
| link_ch_o | output | CHW | linked channel number |
| hw_req_clr_o | output | 1 | hardware request clear pulse |
| err_src_o | output | 1 | source bus error pulse |
| err_dst_o | output | 1 | destination bus error pulse |

## Verification
The copy path is exercised with four patterns. Equal word sizes with a round-trip last-adjustment show whether the addresses return to base and the count reloads. Byte reads with a negative step feeding one word write show lane packing order and sign extension. A small source ring shows whether the masking keeps the upper bits. A source-only loop offset shows that the offset is applied between loops but not after the final one. Idle-cycle counts under each stall code separate per-access stalls from loop overhead, and the link, continuous and error runs tell the minor and major link paths apart.

// File: rtl/xle_pkg.sv
package xle_pkg;
  typedef enum logic [1:0] {LINK_OFF = 2'd0, LINK_MINOR = 2'd1, LINK_MAJOR = 2'd2} link_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_LOOP} xle_state_e;
  localparam int MAX_SIZE_CODE = 5;

  function automatic logic [2:0] clamp_size(input logic [2:0] c);
    return (c > 3'(MAX_SIZE_CODE)) ? 3'(MAX_SIZE_CODE) : c;
  endfunction
endpackage

// File: rtl/xle_addr_step.sv
module xle_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] delta_i,
  input  logic [4:0]    mod_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] sum, win;
  assign sum = addr_i + delta_i;
  always_comb begin
    win = '1;
    if (mod_i != 5'd0) win = (AW'(1) << mod_i) - AW'(1);
    addr_o = (addr_i & ~win) | (sum & win);
  end
endmodule

// File: rtl/xle_stall_ctr.sv
module xle_stall_ctr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic [1:0] code_i,
  output logic       stall_o
);
  localparam logic [3:0] STALL_SHORT = 4'd4;
  localparam logic [3:0] STALL_LONG  = 4'd8;
  logic [3:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (hit_i) begin
      case (code_i)
        2'd2:    cnt_q <= STALL_SHORT;
        2'd3:    cnt_q <= STALL_LONG;
        default: cnt_q <= '0;
      endcase
    end else if (cnt_q != 4'd0) cnt_q <= cnt_q - 4'd1;
  end
  assign stall_o = (cnt_q != 4'd0);
endmodule

// File: rtl/xle_iter_ctr.sv
module xle_iter_ctr #(
  parameter int CW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] biter_i,
  input  logic          dec_i,
  output logic [CW-1:0] citer_o,
  output logic          last_o,
  output logic          half_o
);
  logic [CW-1:0] citer_q, biter_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      citer_q <= '0;
      biter_q <= '0;
    end else if (load_i) begin
      citer_q <= biter_i;
      biter_q <= biter_i;
    end else if (dec_i) begin
      citer_q <= last_o ? biter_q : citer_q - CW'(1);
    end
  end
  assign last_o  = (citer_q == CW'(1));
  assign half_o  = (biter_q >= CW'(2)) && ((citer_q - CW'(1)) == (biter_q >> 1));
  assign citer_o = citer_q;
endmodule

// File: rtl/xfer_loop_engine.sv
module xfer_loop_engine
  import xle_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 15,
  parameter int NBW  = 16,
  parameter int MLW  = 20,
  parameter int MAXB = 32,
  parameter int CHW  = 5,
  parameter logic [CHW-1:0] CH_ID = CHW'(3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              start_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [AW-1:0]     dst_addr_i,
  input  logic [2:0]        src_size_i,
  input  logic [2:0]        dst_size_i,
  input  logic [15:0]       src_step_i,
  input  logic [15:0]       dst_step_i,
  input  logic [4:0]        src_mod_i,
  input  logic [4:0]        dst_mod_i,
  input  logic [NBW-1:0]    minor_bytes_i,
  input  logic [CW-1:0]     major_iter_i,
  input  logic [AW-1:0]     src_last_i,
  input  logic [AW-1:0]     dst_last_i,
  input  logic [MLW-1:0]    loop_off_i,
  input  logic              loop_off_src_en_i,
  input  logic              loop_off_dst_en_i,
  input  logic [1:0]        bw_code_i,
  input  logic              half_ie_i,
  input  logic              major_ie_i,
  input  logic [1:0]        link_mode_i,
  input  logic [CHW-1:0]    link_ch_i,
  input  logic              cont_link_i,
  input  logic              auto_stop_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [2:0]        mem_size_o,
  output logic [8*MAXB-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [8*MAXB-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     src_addr_o,
  output logic [AW-1:0]     dst_addr_o,
  output logic [CW-1:0]     citer_o,
  output logic              int_half_o,
  output logic              int_major_o,
  output logic              link_go_o,
  output logic [CHW-1:0]    link_ch_o,
  output logic              hw_req_clr_o,
  output logic              err_src_o,
  output logic              err_dst_o
);
  localparam int DW   = 8 * MAXB;
  localparam int SUBW = $clog2(MAXB) + 1;
  localparam int IDXW = $clog2(MAXB) + 2;

  xle_state_e       state_q;
  logic [AW-1:0]    src_q, dst_q, src_nxt, dst_nxt, src_step_x, dst_step_x, loop_off_x;
  logic [DW-1:0]    buf_q, buf_fill;
  logic [SUBW-1:0]  sub_q, rd_last, wr_last;
  logic [NBW-1:0]   byte_q;
  logic [NBW:0]     byte_sum;
  logic [2:0]       ssz, dsz, esz;
  logic [IDXW-1:0]  sbytes, dbytes;
  logic             done_q, half_q, major_q, link_q, clr_q, esrc_q, edst_q;
  logic             stall, acc_hit, loop_fire, iter_last, iter_half, self_cont, iter_load;
  link_mode_e       lmode;

  assign ssz     = clamp_size(src_size_i);
  assign dsz     = clamp_size(dst_size_i);
  assign esz     = (ssz > dsz) ? ssz : dsz;
  assign sbytes  = IDXW'(1) << ssz;
  assign dbytes  = IDXW'(1) << dsz;
  assign rd_last = (SUBW'(1) << (esz - ssz)) - SUBW'(1);
  assign wr_last = (SUBW'(1) << (esz - dsz)) - SUBW'(1);
  assign byte_sum = {1'b0, byte_q} + ((NBW+1)'(1) << esz);

  assign src_step_x = {{(AW-16){src_step_i[15]}}, src_step_i};
  assign dst_step_x = {{(AW-16){dst_step_i[15]}}, dst_step_i};
  assign loop_off_x = {{(AW-MLW){loop_off_i[MLW-1]}}, loop_off_i};

  assign lmode     = link_mode_e'(link_mode_i);
  assign self_cont = cont_link_i && (lmode == LINK_MINOR) && (link_ch_i == CH_ID);

  assign mem_req_o  = ((state_q == ST_READ) || (state_q == ST_WRITE)) && !stall;
  assign mem_we_o   = (state_q == ST_WRITE);
  assign mem_addr_o = mem_we_o ? dst_q : src_q;
  assign mem_size_o = mem_we_o ? dst_size_i : src_size_i;
  assign acc_hit    = mem_req_o && mem_ack_i;
  assign loop_fire  = (state_q == ST_LOOP) && !stall;
  assign iter_load  = load_i && (state_q == ST_IDLE);
  assign mem_wdata_o = buf_q >> {IDXW'(sub_q) * dbytes, 3'b000};

  // place read bytes into the element buffer at sub-access position
  always_comb begin
    buf_fill = buf_q;
    for (int b = 0; b < MAXB; b++) begin
      logic [IDXW-1:0] idx;
      idx = IDXW'(sub_q) * sbytes + IDXW'(b);
      if ((IDXW'(b) < sbytes) && (idx < IDXW'(MAXB)))
        buf_fill[idx*8 +: 8] = mem_rdata_i[b*8 +: 8];
    end
  end

  xle_addr_step #(.AW(AW)) u_src_step (
    .addr_i(src_q), .delta_i(src_step_x), .mod_i(src_mod_i), .addr_o(src_nxt));
  xle_addr_step #(.AW(AW)) u_dst_step (
    .addr_i(dst_q), .delta_i(dst_step_x), .mod_i(dst_mod_i), .addr_o(dst_nxt));

  xle_stall_ctr u_stall (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(acc_hit), .code_i(bw_code_i), .stall_o(stall));

  xle_iter_ctr #(.CW(CW)) u_iter (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(iter_load), .biter_i(major_iter_i),
    .dec_i(loop_fire), .citer_o(citer_o), .last_o(iter_last), .half_o(iter_half));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      buf_q   <= '0;
      sub_q   <= '0;
      byte_q  <= '0;
      done_q  <= 1'b0;
      half_q  <= 1'b0;
      major_q <= 1'b0;
      link_q  <= 1'b0;
      clr_q   <= 1'b0;
      esrc_q  <= 1'b0;
      edst_q  <= 1'b0;
    end else begin
      half_q  <= 1'b0;
      major_q <= 1'b0;
      link_q  <= 1'b0;
      clr_q   <= 1'b0;
      esrc_q  <= 1'b0;
      edst_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            src_q  <= src_addr_i;
            dst_q  <= dst_addr_i;
            done_q <= 1'b0;
          end else if (start_i) begin
            state_q <= ST_READ;
            sub_q   <= '0;
            byte_q  <= '0;
            done_q  <= 1'b0;
          end
        end
        ST_READ: if (acc_hit) begin
          if (mem_err_i) begin
            esrc_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            buf_q <= buf_fill;
            src_q <= src_nxt;
            if (sub_q == rd_last) begin
              sub_q   <= '0;
              state_q <= ST_WRITE;
            end else sub_q <= sub_q + SUBW'(1);
          end
        end
        ST_WRITE: if (acc_hit) begin
          if (mem_err_i) begin
            edst_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            dst_q <= dst_nxt;
            if (sub_q == wr_last) begin
              sub_q <= '0;
              if (byte_sum >= {1'b0, minor_bytes_i}) begin
                byte_q  <= '0;
                state_q <= ST_LOOP;
              end else begin
                byte_q  <= byte_sum[NBW-1:0];
                state_q <= ST_READ;
              end
            end else sub_q <= sub_q + SUBW'(1);
          end
        end
        ST_LOOP: if (!stall) begin
          half_q <= half_ie_i && iter_half;
          if (iter_last) begin
            src_q   <= src_q + src_last_i;
            dst_q   <= dst_q + dst_last_i;
            done_q  <= 1'b1;
            major_q <= major_ie_i;
            clr_q   <= auto_stop_i;
            link_q  <= (lmode == LINK_MINOR) || (lmode == LINK_MAJOR);
            state_q <= ST_IDLE;
          end else begin
            if (loop_off_src_en_i) src_q <= src_q + loop_off_x;
            if (loop_off_dst_en_i) dst_q <= dst_q + loop_off_x;
            link_q  <= (lmode == LINK_MINOR) && !self_cont;
            state_q <= self_cont ? ST_READ : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign src_addr_o   = src_q;
  assign dst_addr_o   = dst_q;
  assign int_half_o   = half_q;
  assign int_major_o  = major_q;
  assign link_go_o    = link_q;
  assign link_ch_o    = link_ch_i;
  assign hw_req_clr_o = clr_q;
  assign err_src_o    = esrc_q;
  assign err_dst_o    = edst_q;
endmodule

// File: rtl/xle_checker.sv
module xle_checker #(
  parameter int CW = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic [1:0]    bw_code_i,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] citer_o,
  input logic          int_major_o,
  input logic          hw_req_clr_o,
  input logic          err_src_o,
  input logic          err_dst_o
);
  assert_req_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  assert_count_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (citer_o != '0));
  assert_count_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load_i) |=> $stable(citer_o));
  assert_stall_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && bw_code_i[1]) |=> !mem_req_o);
  assert_major_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_major_o |-> done_o);
  assert_autostop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_req_clr_o |-> (done_o && !busy_o));
  assert_err_end_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_src_o || err_dst_o) |-> (!busy_o && !done_o && $onehot({err_src_o, err_dst_o})));
endmodule

bind xfer_loop_engine xle_checker #(.CW(CW)) u_chk (.*);

// File: tb/xfer_loop_engine_tb.sv
module xfer_loop_engine_tb;
  localparam int AW = 32, CW = 15, NBW = 16, MLW = 20, MAXB = 32, CHW = 5, DW = 8*MAXB;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic load, start;
  logic [AW-1:0] src_a, dst_a, src_l, dst_l;
  logic [2:0] ssz, dsz;
  logic [15:0] sstep, dstep;
  logic [4:0] smod, dmod;
  logic [NBW-1:0] nbytes;
  logic [CW-1:0] biter;
  logic [MLW-1:0] loff;
  logic loff_s, loff_d, hie, mie, cont, astop;
  logic [1:0] bwc, lmode;
  logic [CHW-1:0] lch;
  logic req, we, ack, err;
  logic [AW-1:0] addr;
  logic [2:0] msz;
  logic [DW-1:0] wdata, rdata;
  logic busy, done, ihalf, imajor, lgo, hclr, esrc, edst;
  logic [AW-1:0] src_o, dst_o;
  logic [CW-1:0] citer;
  logic [CHW-1:0] lch_o;

  xfer_loop_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .start_i(start),
    .src_addr_i(src_a), .dst_addr_i(dst_a), .src_size_i(ssz), .dst_size_i(dsz),
    .src_step_i(sstep), .dst_step_i(dstep), .src_mod_i(smod), .dst_mod_i(dmod),
    .minor_bytes_i(nbytes), .major_iter_i(biter), .src_last_i(src_l), .dst_last_i(dst_l),
    .loop_off_i(loff), .loop_off_src_en_i(loff_s), .loop_off_dst_en_i(loff_d),
    .bw_code_i(bwc), .half_ie_i(hie), .major_ie_i(mie), .link_mode_i(lmode),
    .link_ch_i(lch), .cont_link_i(cont), .auto_stop_i(astop),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_size_o(msz),
    .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_err_i(err), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .src_addr_o(src_o), .dst_addr_o(dst_o), .citer_o(citer),
    .int_half_o(ihalf), .int_major_o(imajor), .link_go_o(lgo), .link_ch_o(lch_o),
    .hw_req_clr_o(hclr), .err_src_o(esrc), .err_dst_o(edst));

  function automatic logic [7:0] init_val(input int a);
    return 8'(a * 7 + 3);
  endfunction

  // memory model: one wait cycle per access, optional error on one address
  logic [7:0] mem [256];
  logic err_arm, err_we;
  logic [7:0] err_at;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) mem[a] <= init_val(a);
      ack <= 0; err <= 0; rdata <= '0;
    end else if (ack) begin
      ack <= 0; err <= 0;
    end else if (req) begin
      logic hit;
      hit = err_arm && (addr[7:0] == err_at) && (we == err_we);
      ack <= 1; err <= hit;
      for (int b = 0; b < MAXB; b++) begin
        if (b < (1 << msz)) begin
          if (we && !hit) mem[8'(addr[7:0] + b)] <= wdata[b*8 +: 8];
          if (!we) rdata[b*8 +: 8] <= mem[8'(addr[7:0] + b)];
        end
      end
    end
  end

  int n_half, n_major, n_link, n_clr, n_esrc, n_edst, n_rd, n_wr, n_idle;
  logic [CHW-1:0] seen_ch;
  logic clr;
  always @(posedge clk) begin
    if (clr) begin
      n_half <= 0; n_major <= 0; n_link <= 0; n_clr <= 0; n_esrc <= 0;
      n_edst <= 0; n_rd <= 0; n_wr <= 0; n_idle <= 0; seen_ch <= '0;
    end else begin
      if (ihalf) n_half <= n_half + 1;
      if (imajor) n_major <= n_major + 1;
      if (lgo) begin n_link <= n_link + 1; seen_ch <= lch_o; end
      if (hclr) n_clr <= n_clr + 1;
      if (esrc) n_esrc <= n_esrc + 1;
      if (edst) n_edst <= n_edst + 1;
      if (req && ack && !err && !we) n_rd <= n_rd + 1;
      if (req && ack && !err && we) n_wr <= n_wr + 1;
      if (busy && !req) n_idle <= n_idle + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_default();
    src_a = 0; dst_a = 0; src_l = 0; dst_l = 0; ssz = 0; dsz = 0; sstep = 1; dstep = 1;
    smod = 0; dmod = 0; nbytes = 1; biter = 1; loff = 0; loff_s = 0; loff_d = 0;
    hie = 0; mie = 0; cont = 0; astop = 0; bwc = 0; lmode = 0; lch = 0; err_arm = 0;
    err_we = 0; err_at = 0;
  endtask
  task automatic clear_counts();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask
  task automatic do_load();
    @(negedge clk) load = 1;
    @(negedge clk) load = 0;
    clear_counts();
  endtask
  task automatic do_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset req", req, 0);
    chk("R6 reset count", citer, 0);
  endtask

  task automatic t_basic();
    cfg_default();
    src_a = 0; dst_a = 8'h80; ssz = 2; dsz = 2; sstep = 4; dstep = 4; nbytes = 8; biter = 2;
    src_l = -32'sd16; dst_l = -32'sd16; hie = 1; mie = 1;
    do_load();
    chk("R1 load count", citer, 2);
    do_start();
    chk("R5 count after one loop", citer, 1);
    chk("R3 src after one loop", src_o, 8);
    chk("R1 done clear mid", done, 0);
    chk("R9 half at count 1", n_half, 1);
    do_start();
    for (int i = 0; i < 16; i++) chk("R2 word copy", mem[8'h80 + i], init_val(i));
    chk("R6 src back to base", src_o, 0);
    chk("R6 dst back to base", dst_o, 8'h80);
    chk("R6 count reload", citer, 2);
    chk("R6 done set", done, 1);
    chk("R10 major pulse", n_major, 1);
  endtask

  task automatic t_widths();
    cfg_default();
    src_a = 8'h43; dst_a = 8'h90; ssz = 0; dsz = 2; sstep = 16'hFFFF; dstep = 4; nbytes = 4;
    do_load(); do_start();
    chk("R2 narrow reads", n_rd, 4);
    chk("R2 wide writes", n_wr, 1);
    for (int i = 0; i < 4; i++) chk("R2 lane order", mem[8'h90 + i], init_val(8'h43 - i));
    chk("R3 negative step", src_o, 8'h3F);
    chk("R3 dst step", dst_o, 8'h94);
  endtask

  task automatic t_modulo();
    cfg_default();
    src_a = 8'h10; dst_a = 8'hA0; smod = 3; nbytes = 12;
    do_load(); do_start();
    for (int i = 0; i < 12; i++) chk("R4 ring read", mem[8'hA0 + i], init_val(8'h10 + (i % 8)));
    chk("R4 src wrapped", src_o, 8'h14);
    chk("R4 dst linear", dst_o, 8'hAC);
  endtask

  task automatic t_loop_off();
    cfg_default();
    src_a = 8'h20; dst_a = 8'hB0; nbytes = 4; biter = 2; loff = 4; loff_s = 1;
    do_load(); do_start();
    chk("R7 src after offset", src_o, 8'h28);
    chk("R7 dst no offset", dst_o, 8'hB4);
    do_start();
    for (int i = 0; i < 4; i++) chk("R7 first block", mem[8'hB0 + i], init_val(8'h20 + i));
    for (int i = 0; i < 4; i++) chk("R7 second block", mem[8'hB4 + i], init_val(8'h28 + i));
    chk("R7 no offset on final", src_o, 8'h2C);
  endtask

  task automatic t_bandwidth();
    int exp_idle [3] = '{1, 33, 65};
    logic [1:0] codes [3] = '{2'd0, 2'd2, 2'd3};
    for (int k = 0; k < 3; k++) begin
      cfg_default();
      src_a = 0; dst_a = 8'hC0; nbytes = 4; bwc = codes[k];
      do_load(); do_start();
      chk("R8 idle cycles", n_idle, exp_idle[k]);
    end
  endtask

  task automatic t_links();
    cfg_default();
    src_a = 8'h30; dst_a = 8'hE0; biter = 3; lmode = 1; lch = 5; astop = 1;
    do_load();
    do_start(); do_start();
    chk("R12 no clear early", n_clr, 0);
    do_start();
    chk("R11 minor link pulses", n_link, 3);
    chk("R11 link channel", seen_ch, 5);
    chk("R12 clear at completion", n_clr, 1);
    lmode = 2; astop = 0;
    do_load();
    do_start(); do_start();
    chk("R11 major link early", n_link, 0);
    do_start();
    chk("R11 major link once", n_link, 1);
    chk("R12 no clear when off", n_clr, 0);
  endtask

  task automatic t_continuous();
    cfg_default();
    src_a = 8'h30; dst_a = 8'hE8; biter = 3; lmode = 1; lch = 3; cont = 1;
    do_load(); do_start();
    chk("R13 whole loop from one start", done, 1);
    chk("R13 reads", n_rd, 3);
    chk("R13 only final link", n_link, 1);
    chk("R13 count reload", citer, 3);
  endtask

  task automatic t_half();
    cfg_default();
    src_a = 8'h30; dst_a = 8'hF0; biter = 4; hie = 1; mie = 0;
    do_load(); do_start();
    chk("R9 no half yet", n_half, 0);
    do_start();
    chk("R9 half at count 2", n_half, 1);
    do_start(); do_start();
    chk("R9 half only once", n_half, 1);
    chk("R10 major masked", n_major, 0);
    chk("R6 done with masked irq", done, 1);
  endtask

  task automatic t_errors();
    cfg_default();
    src_a = 8'h04; dst_a = 8'hD0; nbytes = 4; err_arm = 1; err_we = 0; err_at = 8'h05;
    do_load(); do_start();
    chk("R14 src error pulse", n_esrc, 1);
    chk("R14 no dst error", n_edst, 0);
    chk("R14 writes before error", n_wr, 1);
    chk("R14 first byte moved", mem[8'hD0], init_val(4));
    chk("R14 later byte untouched", mem[8'hD1], init_val(8'hD1));
    chk("R14 no done on error", done, 0);
    cfg_default();
    src_a = 8'h04; dst_a = 8'hD8; nbytes = 4; err_arm = 1; err_we = 1; err_at = 8'hD8;
    do_load(); do_start();
    chk("R14 dst error pulse", n_edst, 1);
    chk("R14 failed write stores nothing", mem[8'hD8], init_val(8'hD8));
    chk("R14 idle after error", busy, 0);
    err_arm = 0;
  endtask

  initial begin
    load = 0; start = 0; clr = 0;
    cfg_default();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_widths();
    t_modulo();
    t_loop_off();
    t_bandwidth();
    t_links();
    t_continuous();
    t_half();
    t_errors();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule